// File: doc/BRIEF.md
# DDS Phase Accumulator Core

This block is the digital heart of a direct digital synthesizer. On every system clock a 32-bit phase accumulator advances by a frequency tuning word. The output frequency is therefore tuning_word × f_clk / 2^32, and words of 2^31 and above stand for negative (aliased) frequencies. The top 14 bits of the accumulator are added to a 14-bit phase offset. The sum is turned into a signed 14-bit cosine sample by a quarter-wave lookup whose contents are computed at elaboration.

Configuration arrives through a simple write port. Every write lands in a staging copy and has no effect on the running datapath until an update strobe moves the staging copy into the active copy. A clear-phase control holds the accumulator at zero. After reset the active clear bit is set and its staging copy is not, so the output sits at zero phase until the first update. A live external word can replace either the tuning word or the phase offset, chosen by a destination bit. This lets a fast source modulate frequency or phase without register writes.

Top module: `dds_core`

## Requirements
- R1: After reset the accumulator output is 0, the active clear bit is 1, the staged clear bit is 0, and the amplitude output equals the cosine of phase 0 (+8191).
- R2: Until the first update strobe, the accumulator stays at 0 whatever is written through the write port.
- R3: Write address 0 loads the staged tuning word (32 bits). Address 1 loads the staged phase offset from wr_data[13:0]. Address 2 loads the staged control bits: bit 0 clear-phase, bit 1 external-word enable, bit 2 external-word destination. A write alone changes neither the accumulator rate nor the amplitude output.
- R4: An update strobe sampled high at clock edge k copies all staged values to the active values at edge k+1. The accumulator first uses them at edge k+2.
- R5: When clear is inactive, the accumulator adds the effective tuning word at every edge, modulo 2^32, and wraps around.
- R6: A tuning word of 0 freezes the accumulator at its current value. It does not return it to 0.
- R7: While the active clear bit is 1, the accumulator is 0 from the next edge onward. After the bit is released it restarts from 0.
- R8: The phase fed to the lookup is (accumulator[31:18] + offset) mod 2^14. The amplitude output reflects the accumulator value two edges after that value appears.
- R9: For a 14-bit phase p, the amplitude equals round(8191 × cos(2π(floor(p/16)+0.5)/1024)) within ±1, in two's complement. It is non-positive in the second and third quadrants (p[13] xor p[12] = 1) and non-negative otherwise.
- R10: With external enable 1 and destination 0, ext_word is used live as the tuning word and the staged and active tuning words are ignored.
- R11: With external enable 1 and destination 1, ext_word[31:18] is used live as the phase offset, the offset register is ignored, and the tuning word still comes from the active register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_addr | input | 2 | Staging register select (0 tuning, 1 offset, 2 control) |
| wr_data | input | 32 | Write data |
| upd | input | 1 | Update strobe: staged values become active one edge after it is sampled |
| ext_word | input | 32 | Live external tuning or offset word |
| acc_out | output | 32 | Phase accumulator value |
| amp_out | output | 14 | Signed cosine amplitude sample |

## Verification
The update strobe takes two edges to reach the active registers. Those values then steer the accumulator on the following edge. The amplitude trails the accumulator by two further edges: one for the offset adder, one for the lookup. Every check is timed against this count. The bench drives inputs and samples outputs on falling edges. After an update task returns, the accumulator still shows the value computed under the old configuration, and the first step under the new configuration is checked one cycle later. Amplitude checks compare the output with the accumulator value sampled exactly two cycles earlier. They also confirm that the old amplitude is still present one cycle before a new offset is due.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef struct packed {
        logic clr;
        logic ext_en;
        logic ext_dst;
    } ctl_t;

    // Quarter-wave cosine magnitude for table slot j of qn slots, scaled to amax.
    // Fixed-point Taylor series in Q30; slot j sits at angle (j+0.5)*(pi/2)/qn.
    function automatic longint cos_mag(input int j, input int qn, input int amax);
        longint x;
        longint t;
        longint s;
        x = (longint'(2 * j + 1) * 64'sd1686629713) / longint'(2 * qn);
        t = 64'sd1 <<< 30;
        s = t;
        for (int k = 1; k <= 7; k++) begin
            t = (t * x) >>> 30;
            t = (t * x) >>> 30;
            t = -t / longint'((2 * k - 1) * (2 * k));
            s = s + t;
        end
        if (s < 0) s = 0;
        return (s * longint'(amax) + (64'sd1 <<< 29)) >>> 30;
    endfunction

endpackage

// File: rtl/dds_regs.sv
module dds_regs
    import dds_pkg::*;
#(
    parameter int FTW_W = 32,
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [FTW_W-1:0] wr_data,
    input  logic             upd,
    output logic [FTW_W-1:0] act_ftw,
    output logic [OFS_W-1:0] act_ofs,
    output ctl_t             act_ctl
);
    localparam logic [1:0] ADDR_FTW = 2'd0;
    localparam logic [1:0] ADDR_OFS = 2'd1;
    localparam logic [1:0] ADDR_CTL = 2'd2;
    localparam int CTL_CLR = 0;
    localparam int CTL_EXT = 1;
    localparam int CTL_DST = 2;

    typedef struct packed {
        logic [FTW_W-1:0] sh_ftw;
        logic [OFS_W-1:0] sh_ofs;
        ctl_t             sh_ctl;
        logic             upd;
        logic [FTW_W-1:0] ftw;
        logic [OFS_W-1:0] ofs;
        ctl_t             ctl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.upd = upd;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_FTW: st_d.sh_ftw = wr_data;
                ADDR_OFS: st_d.sh_ofs = wr_data[OFS_W-1:0];
                ADDR_CTL: begin
                    st_d.sh_ctl.clr     = wr_data[CTL_CLR];
                    st_d.sh_ctl.ext_en  = wr_data[CTL_EXT];
                    st_d.sh_ctl.ext_dst = wr_data[CTL_DST];
                end
                default: ;
            endcase
        end
        if (st_q.upd) begin
            st_d.ftw = st_q.sh_ftw;
            st_d.ofs = st_q.sh_ofs;
            st_d.ctl = st_q.sh_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.ctl.clr <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_ftw = st_q.ftw;
    assign act_ofs = st_q.ofs;
    assign act_ctl = st_q.ctl;

    // R4
    upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |=> (act_ftw == $past(st_q.sh_ftw)) && (act_ofs == $past(st_q.sh_ofs))
                     && (act_ctl == $past(st_q.sh_ctl)));

    // R3
    no_upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.upd |=> $stable(act_ftw) && $stable(act_ofs) && $stable(act_ctl));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] act_ftw,
    input  logic [PH_W-1:0]  act_ofs,
    input  ctl_t             act_ctl,
    input  logic [ACC_W-1:0] ext_word,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  ph_q
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [PH_W-1:0]  ph;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] ftw_eff;
    logic [PH_W-1:0]  ofs_eff;
    logic             ext_to_ftw;
    logic             ext_to_ofs;

    always_comb begin
        ext_to_ftw = act_ctl.ext_en && !act_ctl.ext_dst;
        ext_to_ofs = act_ctl.ext_en && act_ctl.ext_dst;
        ftw_eff    = ext_to_ftw ? ext_word : act_ftw;
        ofs_eff    = ext_to_ofs ? ext_word[ACC_W-1 -: PH_W] : act_ofs;
        st_d.acc   = act_ctl.clr ? '0 : st_q.acc + ftw_eff;
        st_d.ph    = st_q.acc[ACC_W-1 -: PH_W] + ofs_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q = st_q.acc;
    assign ph_q  = st_q.ph;

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_ctl.clr |=> (acc_q == '0));

    // R6
    zero_ftw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_ctl.clr && !act_ctl.ext_en && (act_ftw == '0)) |=> $stable(acc_q));

    // R10
    ext_ftw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ctl.ext_en && !act_ctl.ext_dst && !act_ctl.clr)
            |=> (acc_q == $past(acc_q) + $past(ext_word)));

endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut #(
    parameter int PH_W  = 14,
    parameter int LUT_W = 8,
    parameter int AMP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  ph_in,
    output logic [AMP_W-1:0] amp_q
);
    localparam int QN    = 1 << LUT_W;
    localparam int IDX_W = LUT_W + 2;
    localparam int AMAX  = (1 << (AMP_W - 1)) - 1;

    logic [AMP_W-2:0] rom [QN];

    for (genvar i = 0; i < QN; i++) begin : g_rom
        localparam longint MAG = dds_pkg::cos_mag(i, QN, AMAX);
        assign rom[i] = MAG[AMP_W-2:0];
    end

    typedef struct packed {
        logic [AMP_W-1:0] amp;
    } lut_state_t;

    lut_state_t st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic [1:0]       quad;
    logic [LUT_W-1:0] slot;
    logic [AMP_W-2:0] mag;
    logic             unused_low_phase;

    assign unused_low_phase = ^ph_in[PH_W-IDX_W-1:0];

    always_comb begin
        idx  = ph_in[PH_W-1 -: IDX_W];
        quad = idx[IDX_W-1 -: 2];
        slot = idx[LUT_W-1:0];
        mag  = quad[0] ? rom[~slot] : rom[slot];
        st_d.amp = (quad[1] ^ quad[0]) ? -{1'b0, mag} : {1'b0, mag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign amp_q = st_q.amp;

    // R9
    neg_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_in[PH_W-1] ^ ph_in[PH_W-2]) |=> ($signed(amp_q) <= 0));

    // R9
    pos_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_in[PH_W-1] ^ ph_in[PH_W-2]) |=> ($signed(amp_q) >= 0));

endmodule

// File: rtl/dds_core.sv
module dds_core
    import dds_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 14,
    parameter int LUT_W = 8,
    parameter int AMP_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             upd,
    input  logic [ACC_W-1:0] ext_word,
    output logic [ACC_W-1:0] acc_out,
    output logic [AMP_W-1:0] amp_out
);
    logic [ACC_W-1:0] act_ftw;
    logic [PH_W-1:0]  act_ofs;
    ctl_t             act_ctl;
    logic [PH_W-1:0]  ph;

    dds_regs #(.FTW_W(ACC_W), .OFS_W(PH_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .upd     (upd),
        .act_ftw (act_ftw),
        .act_ofs (act_ofs),
        .act_ctl (act_ctl)
    );

    dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_ftw  (act_ftw),
        .act_ofs  (act_ofs),
        .act_ctl  (act_ctl),
        .ext_word (ext_word),
        .acc_q    (acc_out),
        .ph_q     (ph)
    );

    dds_cos_lut #(.PH_W(PH_W), .LUT_W(LUT_W), .AMP_W(AMP_W)) u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .ph_in (ph),
        .amp_q (amp_out)
    );

    // R8
    phase_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_ctl.ext_en) |=> (ph == $past(acc_out[ACC_W-1 -: PH_W] + act_ofs)));

endmodule

// File: tb/dds_core_bench.sv
module dds_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        upd = 1'b0;
    logic [31:0] ext_word = '0;
    logic [31:0] acc_out;
    logic [13:0] amp_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dds_core u_dds_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd(upd), .ext_word(ext_word),
        .acc_out(acc_out), .amp_out(amp_out)
    );

    function automatic int exp_amp(input logic [13:0] p);
        int  idx;
        real ang;
        idx = int'(p >> 4);
        ang = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / 1024.0;
        return int'(8191.0 * $cos(ang));
    endfunction

    task automatic chk_acc(input string tag, input logic [31:0] exp);
        n_chk++;
        if (acc_out !== exp) begin
            n_bad++;
            $display("FAIL %s acc actual=%h expected=%h", tag, acc_out, exp);
        end
    endtask

    task automatic chk_amp(input string tag, input logic [13:0] p);
        int a;
        int e;
        a = int'($signed(amp_out));
        e = exp_amp(p);
        n_chk++;
        if (a > e + 1 || a < e - 1) begin
            n_bad++;
            $display("FAIL %s amp actual=%0d expected=%0d", tag, a, e);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // returns on the falling edge after the active copy is loaded
    task automatic update(output logic [31:0] mid);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        mid = acc_out;
        @(negedge clk);
    endtask

    logic [31:0] ftw_a = 32'h3000_0001;
    logic [31:0] ftw_b = 32'h0123_4567;

    task automatic t_reset();
        chk_acc("R1 reset", 32'h0);
        chk_amp("R1 reset", 14'h0);
    endtask

    task automatic t_hold();
        wr(2'd0, ftw_a);
        wr(2'd1, 32'h0000_1000);
        for (int i = 0; i < 6; i++) begin
            step(1);
            chk_acc("R2 hold", 32'h0);
        end
        chk_amp("R3 staged offset ignored", 14'h0);
        wr(2'd1, 32'h0);
    endtask

    task automatic t_run();
        logic [31:0] m;
        update(m);
        chk_acc("R4 old config at load", 32'h0);
        for (int k = 1; k <= 40; k++) begin
            step(1);
            chk_acc("R5 accumulate", ftw_a * k);
        end
    endtask

    task automatic t_amp_run();
        logic [31:0] hist [32];
        for (int i = 0; i < 32; i++) begin
            hist[i] = acc_out;
            if (i >= 2) chk_amp("R8 latency", hist[i-2][31:18]);
            step(1);
        end
    endtask

    task automatic t_shadow();
        logic [31:0] a0;
        logic [31:0] m;
        wr(2'd0, ftw_b);
        a0 = acc_out;
        step(1);
        chk_acc("R3 write ignored", a0 + ftw_a);
        update(m);
        chk_acc("R4 old step at load", m + ftw_a);
        a0 = acc_out;
        step(1);
        chk_acc("R4 new step", a0 + ftw_b);
    endtask

    task automatic t_freeze();
        logic [31:0] a0;
        logic [31:0] m;
        wr(2'd0, 32'h0);
        update(m);
        a0 = acc_out;
        n_chk++;
        if (a0 == 32'h0) begin
            n_bad++;
            $display("FAIL R6 frozen value actual=%h expected=nonzero", a0);
        end
        for (int i = 0; i < 8; i++) begin
            step(1);
            chk_acc("R6 freeze", a0);
        end
    endtask

    task automatic t_clear();
        logic [31:0] a0;
        logic [31:0] m;
        a0 = acc_out;
        wr(2'd0, ftw_b);
        wr(2'd2, 32'h1);
        update(m);
        chk_acc("R7 before clear", a0);
        step(1);
        chk_acc("R7 cleared", 32'h0);
        step(3);
        chk_acc("R7 stays cleared", 32'h0);
        wr(2'd2, 32'h0);
        update(m);
        chk_acc("R7 release", 32'h0);
        step(1);
        chk_acc("R7 restart 1", ftw_b);
        step(1);
        chk_acc("R7 restart 2", ftw_b * 2);
    endtask

    task automatic t_offset();
        logic [13:0] offs [8];
        logic [13:0] prev;
        logic [31:0] m;
        offs = '{14'h1000, 14'h2000, 14'h3000, 14'h0FFF,
                 14'h2345, 14'h3FFF, 14'h1800, 14'h0000};
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h1);
        update(m);
        step(3);
        prev = 14'h0;
        foreach (offs[i]) begin
            wr(2'd1, {18'h0, offs[i]});
            update(m);
            step(1);
            chk_amp("R8 not yet", prev);
            step(1);
            chk_amp("R9 cosine", offs[i]);
            prev = offs[i];
        end
    endtask

    task automatic t_ext_ftw();
        logic [31:0] e;
        logic [31:0] m;
        e = 32'h0800_0003;
        ext_word = e;
        wr(2'd0, 32'h0000_1111);
        wr(2'd2, 32'h2);
        update(m);
        chk_acc("R10 load", 32'h0);
        for (int k = 1; k <= 10; k++) begin
            step(1);
            chk_acc("R10 ext tuning", e * k);
        end
    endtask

    task automatic t_ext_ofs();
        logic [31:0] h;
        logic [31:0] a0;
        logic [31:0] m;
        h = 32'h0004_0000;
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0000_0100);
        wr(2'd2, 32'h7);
        ext_word = {14'h2800, 18'h0};
        update(m);
        step(3);
        chk_acc("R11 held", 32'h0);
        chk_amp("R11 ext offset", 14'h2800);
        ext_word = {14'h0C00, 18'h0};
        step(2);
        chk_amp("R11 live ext offset", 14'h0C00);
        wr(2'd0, h);
        wr(2'd2, 32'h6);
        update(m);
        a0 = acc_out;
        step(1);
        chk_acc("R11 tuning from register", a0 + h);
        step(1);
        chk_acc("R11 tuning from register 2", a0 + h * 2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_hold();
        t_run();
        t_amp_run();
        t_shadow();
        t_freeze();
        t_clear();
        t_offset();
        t_ext_ftw();
        t_ext_ofs();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule